// File: doc/BRIEF.md
# Multi-Cycle Accumulator Processor Core

This block is a small stored-program processor built around one accumulator. It fetches a 16-bit instruction word from the same memory that holds its data. A sequencer walks each instruction through fixed register-transfer steps. All memory traffic passes through an address holding register and a data buffer register. The program counter, instruction register, accumulator and a four-bit condition register make up the rest of the visible state.

The core drives one synchronous single-port memory: an address, write data, a write strobe, and read data that arrives one cycle after the address. A literal operand goes from the instruction's low field straight into the data buffer register, with no memory cycle. A branch tests the zero flag and either keeps the sequential program counter or loads the branch target. Execution starts at address 0 after reset. A halt instruction parks the core until the next reset.

Top module: `acc_core`

## Requirements
- R1: A synchronous active-low reset clears the program counter, accumulator, instruction register and all flags. While reset is held, `mem_addr` reads 0, `mem_we` reads 0 and `cond_flags` reads 0. Once reset is released, execution starts with the word at address 0.
- R2: Each instruction fetch takes five cycles: address register loaded from PC, PC incremented, read data captured, instruction register loaded, decode. The first cycle after reset release is cycle 0, so the second fetch (word 1) drives `mem_addr` = 1 in cycle 8 when the first instruction is a literal load.
- R3: An instruction word holds the opcode in bits 15:12 and the operand field in bits 11:0. The opcodes are 0 load, 1 store, 2 add, 3 subtract, 4 AND, 5 load literal, 6 add literal, 7 branch on zero, 15 halt.
- R4: Load, add, subtract and AND with a memory operand place the address field in the address register, read that word, and leave accumulator = accumulator op word (load passes the word through).
- R5: Load literal and add literal use the 12-bit field, zero-extended to 16 bits, as the operand without a data read.
- R6: A store writes the accumulator to the word at its address field, with `mem_we` high for exactly one cycle. For a literal load at 0 followed by a store at 1, that write cycle is cycle 14.
- R7: `cond_flags` is {Z,N,V,C} in bits 3..0. Z means the result is zero and N is result bit 15. For add, C is the carry out and V is signed overflow. For subtract, C is set when a borrow occurs (minuend below subtrahend, unsigned) and V is signed overflow.
- R8: Load, load literal and AND update only Z and N. Add, add literal and subtract update all four flags. Store, branch, halt and unused opcodes leave every flag unchanged.
- R9: A branch on zero loads PC from the address field when Z is 1. Otherwise execution continues at the next word.
- R10: Opcodes 8 to 14 do nothing beyond their fetch: no write, and accumulator and flags are kept.
- R11: After a halt, the core makes no memory write and holds `mem_addr` until reset.
- R12: A word written by a store can later be fetched and executed as an instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | ADDR_W | Memory address (the address register) |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | DATA_W | Memory write data (the data buffer register) |
| mem_rdata | input | DATA_W | Memory read data, valid one cycle after the address |
| cond_flags | output | 4 | Condition register {Z,N,V,C} |

## Verification
The bench builds the core with its default widths: 16-bit words and a 12-bit address field. Its memory model decodes only the low 9 address bits, which keeps every program and data location in reach. With full 16-bit data, the signed and unsigned wrap points (0x7FFF, 0x8000, 0xFFFF) are exercised by the add and subtract corner cases. The 12-bit literal field allows the largest literal, 0xFFF, to be checked for zero extension. Random operand pairs drive the memory-operand arithmetic. Directed programs cover branching, no-ops, halting, self-modified code and exact cycle placement of fetch and write.

// File: rtl/acc_pkg.sv
// Package: shared encodings for the accumulator core.
// Assumes a 4-bit opcode at the top of every instruction word.
package acc_pkg;

    localparam int OPC_W = 4;

    // Opcode values decoded from the instruction register
    localparam logic [OPC_W-1:0] OP_LOAD  = 4'd0;
    localparam logic [OPC_W-1:0] OP_STORE = 4'd1;
    localparam logic [OPC_W-1:0] OP_ADD   = 4'd2;
    localparam logic [OPC_W-1:0] OP_SUB   = 4'd3;
    localparam logic [OPC_W-1:0] OP_AND   = 4'd4;
    localparam logic [OPC_W-1:0] OP_LOADI = 4'd5;
    localparam logic [OPC_W-1:0] OP_ADDI  = 4'd6;
    localparam logic [OPC_W-1:0] OP_BEQ   = 4'd7;
    localparam logic [OPC_W-1:0] OP_HALT  = 4'd15;

    typedef enum logic [1:0] {
        FN_PASS,
        FN_ADD,
        FN_SUB,
        FN_AND
    } alu_fn_e;

    typedef enum logic [3:0] {
        ST_F_MAR,
        ST_F_INC,
        ST_F_CAP,
        ST_F_IR,
        ST_DEC,
        ST_X_MAR,
        ST_X_WAIT,
        ST_X_CAP,
        ST_X_LIT,
        ST_X_ALU,
        ST_S_MBR,
        ST_S_WR,
        ST_HALT
    } state_e;

    typedef struct packed {
        logic z;
        logic n;
        logic v;
        logic c;
    } ccr_t;

endpackage

// File: rtl/acc_alu.sv
// Module: acc_alu
// Combinational arithmetic unit. It passes B through, adds, subtracts or ANDs
// two words, and reports the carry/borrow and the signed overflow.
// Assumes that for subtract the carry output means "borrow occurred".
module acc_alu
    import acc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  alu_fn_e      fn,
    output logic [W-1:0] res,
    output logic         carry,
    output logic         ovf
);

    logic [W:0] sum_x;
    logic [W:0] dif_x;

    // Compute the result and both status bits for the selected function
    always_comb begin
        sum_x = {1'b0, op_a} + {1'b0, op_b};
        dif_x = {1'b0, op_a} - {1'b0, op_b};
        res   = op_b;
        carry = 1'b0;
        ovf   = 1'b0;
        case (fn)
            FN_ADD: begin
                res   = sum_x[W-1:0];
                carry = sum_x[W];
                ovf   = (op_a[W-1] == op_b[W-1]) && (sum_x[W-1] != op_a[W-1]);
            end
            FN_SUB: begin
                res   = dif_x[W-1:0];
                carry = dif_x[W];
                ovf   = (op_a[W-1] != op_b[W-1]) && (dif_x[W-1] != op_a[W-1]);
            end
            FN_AND:  res = op_a & op_b;
            default: res = op_b;
        endcase
    end

endmodule

// File: rtl/acc_ctrl.sv
// Module: acc_ctrl
// Sequencer for the fetch and execute phases. It emits one strobe per
// register transfer. Assumes the memory returns read data one cycle after
// the address register changes.
module acc_ctrl
    import acc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OPC_W-1:0] opcode,
    input  logic             zflag,
    output state_e           state,
    output logic             ld_mar_pc,
    output logic             ld_mar_opd,
    output logic             inc_pc,
    output logic             br_take,
    output logic             ld_mbr_mem,
    output logic             ld_mbr_lit,
    output logic             ld_mbr_acc,
    output logic             ld_ir,
    output logic             ld_acc,
    output logic             mem_we,
    output alu_fn_e          alu_fn,
    output logic             upd_vc
);

    state_e state_nx;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_F_MAR;
        else        state <= state_nx;
    end

    // Next-state and per-step transfer strobes
    always_comb begin
        state_nx   = state;
        ld_mar_pc  = 1'b0;
        ld_mar_opd = 1'b0;
        inc_pc     = 1'b0;
        br_take    = 1'b0;
        ld_mbr_mem = 1'b0;
        ld_mbr_lit = 1'b0;
        ld_mbr_acc = 1'b0;
        ld_ir      = 1'b0;
        ld_acc     = 1'b0;
        mem_we     = 1'b0;
        case (state)
            ST_F_MAR:  begin ld_mar_pc  = 1'b1; state_nx = ST_F_INC; end
            ST_F_INC:  begin inc_pc     = 1'b1; state_nx = ST_F_CAP; end
            ST_F_CAP:  begin ld_mbr_mem = 1'b1; state_nx = ST_F_IR;  end
            ST_F_IR:   begin ld_ir      = 1'b1; state_nx = ST_DEC;   end
            ST_DEC: begin
                case (opcode)
                    OP_LOAD, OP_STORE, OP_ADD, OP_SUB, OP_AND: state_nx = ST_X_MAR;
                    OP_LOADI, OP_ADDI: state_nx = ST_X_LIT;
                    OP_BEQ: begin
                        br_take  = zflag;
                        state_nx = ST_F_MAR;
                    end
                    OP_HALT: state_nx = ST_HALT;
                    default: state_nx = ST_F_MAR;
                endcase
            end
            ST_X_MAR: begin
                ld_mar_opd = 1'b1;
                state_nx   = (opcode == OP_STORE) ? ST_S_MBR : ST_X_WAIT;
            end
            ST_X_WAIT: state_nx = ST_X_CAP;
            ST_X_CAP:  begin ld_mbr_mem = 1'b1; state_nx = ST_X_ALU; end
            ST_X_LIT:  begin ld_mbr_lit = 1'b1; state_nx = ST_X_ALU; end
            ST_X_ALU:  begin ld_acc     = 1'b1; state_nx = ST_F_MAR; end
            ST_S_MBR:  begin ld_mbr_acc = 1'b1; state_nx = ST_S_WR;  end
            ST_S_WR:   begin mem_we     = 1'b1; state_nx = ST_F_MAR; end
            ST_HALT:   state_nx = ST_HALT;
            default:   state_nx = ST_F_MAR;
        endcase
    end

    // ALU function and flag mask from the opcode
    always_comb begin
        upd_vc = 1'b0;
        case (opcode)
            OP_ADD, OP_ADDI: begin alu_fn = FN_ADD; upd_vc = 1'b1; end
            OP_SUB:          begin alu_fn = FN_SUB; upd_vc = 1'b1; end
            OP_AND:          alu_fn = FN_AND;
            default:         alu_fn = FN_PASS;
        endcase
    end

endmodule

// File: rtl/acc_core.sv
// Module: acc_core (top)
// One-address processor datapath. It holds the program counter, the address
// and data buffer registers, the instruction register, the accumulator and
// the condition register. Assumes DATA_W = ADDR_W + 4 and a synchronous
// single-port memory with one cycle of read latency.
module acc_core
    import acc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [3:0]        cond_flags
);

    localparam int LIT_PAD = DATA_W - ADDR_W;

    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] mar_q;
    logic [DATA_W-1:0] mbr_q;
    logic [DATA_W-1:0] ir_q;
    logic [DATA_W-1:0] acc_q;
    ccr_t              ccr_q;

    state_e            state;
    logic              ld_mar_pc, ld_mar_opd, inc_pc, br_take;
    logic              ld_mbr_mem, ld_mbr_lit, ld_mbr_acc, ld_ir, ld_acc;
    logic              we_s, upd_vc;
    alu_fn_e           alu_fn;
    logic [DATA_W-1:0] alu_res;
    logic              alu_c, alu_v;

    logic [OPC_W-1:0]  opcode;
    logic [ADDR_W-1:0] operand;

    assign opcode  = ir_q[DATA_W-1 -: OPC_W];
    assign operand = ir_q[ADDR_W-1:0];

    acc_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .opcode     (opcode),
        .zflag      (ccr_q.z),
        .state      (state),
        .ld_mar_pc  (ld_mar_pc),
        .ld_mar_opd (ld_mar_opd),
        .inc_pc     (inc_pc),
        .br_take    (br_take),
        .ld_mbr_mem (ld_mbr_mem),
        .ld_mbr_lit (ld_mbr_lit),
        .ld_mbr_acc (ld_mbr_acc),
        .ld_ir      (ld_ir),
        .ld_acc     (ld_acc),
        .mem_we     (we_s),
        .alu_fn     (alu_fn),
        .upd_vc     (upd_vc)
    );

    acc_alu #(.W(DATA_W)) u_alu (
        .op_a  (acc_q),
        .op_b  (mbr_q),
        .fn    (alu_fn),
        .res   (alu_res),
        .carry (alu_c),
        .ovf   (alu_v)
    );

    // Program counter: sequential step or branch target
    always_ff @(posedge clk) begin
        if (!rst_n)       pc_q <= '0;
        else if (br_take) pc_q <= operand;
        else if (inc_pc)  pc_q <= pc_q + 1'b1;
    end

    // Address register: from PC during fetch, from operand during execute
    always_ff @(posedge clk) begin
        if (!rst_n)          mar_q <= '0;
        else if (ld_mar_pc)  mar_q <= pc_q;
        else if (ld_mar_opd) mar_q <= operand;
    end

    // Data buffer register: read data, literal field or accumulator
    always_ff @(posedge clk) begin
        if (!rst_n)          mbr_q <= '0;
        else if (ld_mbr_mem) mbr_q <= mem_rdata;
        else if (ld_mbr_lit) mbr_q <= {{LIT_PAD{1'b0}}, operand};
        else if (ld_mbr_acc) mbr_q <= acc_q;
    end

    // Instruction register
    always_ff @(posedge clk) begin
        if (!rst_n)     ir_q <= '0;
        else if (ld_ir) ir_q <= mbr_q;
    end

    // Accumulator and condition register update at the ALU step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            ccr_q <= '0;
        end else if (ld_acc) begin
            acc_q   <= alu_res;
            ccr_q.z <= (alu_res == '0);
            ccr_q.n <= alu_res[DATA_W-1];
            if (upd_vc) begin
                ccr_q.v <= alu_v;
                ccr_q.c <= alu_c;
            end
        end
    end

    assign mem_addr   = mar_q;
    assign mem_wdata  = mbr_q;
    assign mem_we     = we_s;
    assign cond_flags = ccr_q;

endmodule

// File: rtl/acc_core_chk.sv
// Module: acc_core_chk
// Property checker bound into acc_core. It watches the sequencer state and
// the datapath registers against the memory-side ports.
module acc_core_chk
    import acc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input state_e            state,
    input logic [ADDR_W-1:0] pc_q,
    input logic [DATA_W-1:0] ir_q,
    input logic [DATA_W-1:0] acc_q,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_we,
    input logic [3:0]        cond_flags
);

    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (mem_addr == '0 && !mem_we && cond_flags == 4'd0));

    p_fetch_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_F_CAP) |-> (mem_addr == ADDR_W'(pc_q - 1'b1)));

    p_write_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    p_write_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> $stable(mem_addr));

    p_zero_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_X_ALU) |=> (cond_flags[3] == (acc_q == '0)));

    p_flags_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_X_ALU) |=> $stable(cond_flags));

    p_branch_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEC && ir_q[DATA_W-1 -: OPC_W] == OP_BEQ && cond_flags[3])
        |=> (pc_q == ir_q[ADDR_W-1:0]));

    p_halt_freeze_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT) |=> (state == ST_HALT && !mem_we && $stable(mem_addr)));

endmodule

bind acc_core acc_core_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .state      (state),
    .pc_q       (pc_q),
    .ir_q       (ir_q),
    .acc_q      (acc_q),
    .mem_addr   (mem_addr),
    .mem_we     (mem_we),
    .cond_flags (cond_flags)
);

// File: tb/sim_acc_core.sv
// Bench: sim_acc_core
// Runs small programs from a bench memory model and compares stored words
// and the flag port with values computed by bench functions.
module sim_acc_core;

    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] FILL = 16'hF000;
    localparam logic [15:0] SENT = 16'hDEAD;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] mem_addr;
    logic        mem_we;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;
    logic [3:0]  cond_flags;

    logic [15:0] mem [0:511];
    int          wcount = 0;
    int          n_chk = 0;
    int          n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_core u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .mem_addr   (mem_addr),
        .mem_we     (mem_we),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .cond_flags (cond_flags)
    );

    // Synchronous single-port memory, one cycle read latency
    always @(posedge clk) begin
        if (mem_we === 1'b1) begin
            mem[mem_addr[8:0]] <= mem_wdata;
            wcount <= wcount + 1;
        end
        mem_rdata <= mem[mem_addr[8:0]];
    end

    function automatic logic [15:0] ins(input int op, input int opd);
        return {op[3:0], opd[11:0]};
    endfunction

    // Expected {flags, result} for op on (acc a, operand b) with prior flags f
    function automatic logic [19:0] ref_op(input int op, input logic [15:0] a,
                                           input logic [15:0] b, input logic [3:0] f);
        logic [16:0] t;
        logic [15:0] y;
        logic v, c;
        v = f[1];
        c = f[0];
        case (op)
            2: begin
                t = {1'b0, a} + {1'b0, b};
                y = t[15:0];
                c = t[16];
                v = (a[15] == b[15]) && (y[15] != a[15]);
            end
            3: begin
                y = a - b;
                c = (a < b);
                v = (a[15] != b[15]) && (y[15] != a[15]);
            end
            4: y = a & b;
            default: y = b;
        endcase
        return {(y == 16'd0), y[15], v, c, y};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int k = 0; k < 512; k++) mem[k] = FILL;
    endtask

    // Hold reset, check the reset state (R1), release at a falling edge
    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R1 addr", {20'd0, mem_addr}, 32'd0);
        chk("R1 we/flags", {27'd0, mem_we, cond_flags}, 32'd0);
        rst_n = 1'b1;
    endtask

    task automatic run(input int cycles);
        do_reset();
        repeat (cycles) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [19:0] e1, e2;
        logic [15:0] a, b;
        int op, wc, ad;
        void'($urandom(32'd4711));

        // Timing of fetch and store (R2, R6)
        clear_mem();
        mem[0] = ins(5, 5);
        mem[1] = ins(1, 16'h102);
        do_reset();
        for (int i = 1; i <= 20; i++) begin
            @(negedge clk);
            if (i == 8)  chk("R2 fetch of word 1 in cycle 8", {20'd0, mem_addr}, 32'd1);
            if (i == 13) chk("R6 no write before cycle 14", {31'd0, mem_we}, 32'd0);
            if (i == 14) chk("R6 write cycle 14", {3'd0, mem_we, mem_addr, mem_wdata}, {3'd0, 1'b1, 12'h102, 16'd5});
            if (i == 15) chk("R6 single-cycle write", {31'd0, mem_we}, 32'd0);
        end

        // Memory-operand arithmetic, corners then random (R3, R4, R7)
        for (int i = 0; i < 40; i++) begin
            case (i)
                0: begin a = 16'h7FFF; b = 16'h0001; op = 2; end
                1: begin a = 16'hFFFF; b = 16'h0001; op = 2; end
                2: begin a = 16'h8000; b = 16'h0001; op = 3; end
                3: begin a = 16'h1234; b = 16'h1234; op = 3; end
                4: begin a = 16'h0001; b = 16'h0002; op = 3; end
                5: begin a = 16'hF0F0; b = 16'h0F0F; op = 4; end
                default: begin
                    a = 16'($urandom);
                    b = 16'($urandom);
                    op = 2 + int'($urandom % 3);
                end
            endcase
            clear_mem();
            mem[0] = ins(0, 16'h100);
            mem[1] = ins(op, 16'h101);
            mem[2] = ins(1, 16'h102);
            mem[16'h100] = a;
            mem[16'h101] = b;
            run(40);
            e1 = ref_op(0, 16'd0, a, 4'd0);
            e2 = ref_op(op, a, b, e1[19:16]);
            chk("R4 stored result", {16'd0, mem[16'h102]}, {16'd0, e2[15:0]});
            chk("R7 flags after op", {28'd0, cond_flags}, {28'd0, e2[19:16]});
        end

        // Flag subsets: V set by add, kept by literal load, store, branch (R8)
        clear_mem();
        mem[0] = ins(0, 16'h100);
        mem[1] = ins(2, 16'h101);
        mem[2] = ins(5, 0);
        mem[3] = ins(1, 16'h105);
        mem[4] = ins(7, 5);
        mem[16'h100] = 16'h7FFF;
        mem[16'h101] = 16'h0001;
        mem[16'h105] = SENT;
        run(60);
        chk("R8 LOADI/STORE/BEQ keep V,C", {28'd0, cond_flags}, 32'b1010);
        chk("R6 store of zero", {16'd0, mem[16'h105]}, 32'd0);

        // C kept by memory load and AND (R8)
        clear_mem();
        mem[0] = ins(0, 16'h100);
        mem[1] = ins(2, 16'h101);
        mem[2] = ins(0, 16'h103);
        mem[3] = ins(4, 16'h104);
        mem[16'h100] = 16'hFFFF;
        mem[16'h101] = 16'h0001;
        mem[16'h103] = 16'h8000;
        mem[16'h104] = 16'h0000;
        run(60);
        chk("R8 LOAD/AND keep C", {28'd0, cond_flags}, 32'b1001);

        // Literal zero extension (R5)
        clear_mem();
        mem[0] = ins(5, 16'hFFF);
        mem[1] = ins(6, 16'h001);
        mem[2] = ins(1, 16'h102);
        run(40);
        chk("R5 literal add", {16'd0, mem[16'h102]}, 32'h1000);
        chk("R5 literal flags", {28'd0, cond_flags}, 32'd0);
        clear_mem();
        mem[0] = ins(5, 16'hFFF);
        mem[1] = ins(1, 16'h102);
        run(30);
        chk("R5 zero-extended literal", {16'd0, mem[16'h102]}, 32'h0FFF);

        // Branch taken (R9)
        clear_mem();
        mem[0] = ins(5, 0);
        mem[1] = ins(7, 4);
        mem[2] = ins(5, 16'h77);
        mem[4] = ins(1, 16'h102);
        mem[16'h102] = SENT;
        run(40);
        chk("R9 branch taken", {16'd0, mem[16'h102]}, 32'd0);

        // Branch not taken (R9)
        clear_mem();
        mem[0] = ins(5, 3);
        mem[1] = ins(7, 5);
        mem[2] = ins(5, 16'h77);
        mem[3] = ins(1, 16'h102);
        mem[5] = ins(1, 16'h103);
        mem[16'h103] = SENT;
        run(50);
        chk("R9 not taken result", {16'd0, mem[16'h102]}, 32'h77);
        chk("R9 target skipped", {16'd0, mem[16'h103]}, {16'd0, SENT});

        // Unused opcodes, then halt freeze (R10, R11)
        clear_mem();
        mem[0] = ins(5, 9);
        mem[1] = ins(16'hA, 16'h102);
        mem[2] = ins(8, 16'h102);
        mem[3] = ins(1, 16'h103);
        mem[16'h102] = SENT;
        run(50);
        chk("R10 no write by unused opcode", {16'd0, mem[16'h102]}, {16'd0, SENT});
        chk("R10 accumulator kept", {16'd0, mem[16'h103]}, 32'd9);
        chk("R10 flags kept", {28'd0, cond_flags}, 32'd0);
        wc = wcount;
        ad = int'(mem_addr);
        repeat (100) @(negedge clk);
        chk("R11 no write after halt", wcount, wc);
        chk("R11 address held", {20'd0, mem_addr}, ad);

        // Self-modified code (R12)
        clear_mem();
        mem[0] = ins(0, 16'h100);
        mem[1] = ins(1, 3);
        mem[2] = ins(5, 0);
        mem[4] = ins(1, 16'h102);
        mem[16'h100] = 16'h5123;
        run(60);
        chk("R12 stored word executed", {16'd0, mem[16'h102]}, 32'h123);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule